// File: doc/BRIEF.md
# Result Threshold Compare Monitor

This block observes the stream of finished conversion results coming out of an analog-to-digital converter. Each result arrives as a one-cycle load strobe with a 4-bit channel number and a 10-bit unsigned value. The block holds two independent compare units. Each unit watches one chosen channel and tests every result from that channel against a programmed threshold. The test is either "below the threshold" or "at or above the threshold". Each unit counts matching results in a row. When the run length reaches the programmed target plus one, the unit sets a sticky flag.

The two flags sit in one shared status word. Software clears a flag by writing a one to its bit. A single interrupt output is asserted while any flag is set and that unit's interrupt enable is on.

Configuration uses a small write-only register port. Address 0 configures unit 0, address 1 configures unit 1, and address 2 is the status word with write-one-to-clear bits. Bit i of the status word belongs to unit i.

The configuration word has these fields:

| Bits | Field |
|---|---|
| 0 | unit enable |
| 1 | interrupt enable |
| 2 | condition (0 = below, 1 = at or above) |
| 6:3 | channel select |
| 10:7 | target |
| 20:11 | threshold |

Top module: `result_cmp_monitor`

## Requirements
- R1: A unit examines a result only when it is enabled (config bit 0 = 1), `res_load` is high, and `res_chan` equals its channel select (config bits 6:3). Results on other channels, and all results while the unit is disabled, leave its flag and its match count unchanged.
- R2: Channel select codes 0 to 12 are valid. Codes 13, 14 and 15 never match, even when `res_chan` carries the same code.
- R3: With condition bit 2 = 0, a result matches when it is strictly below the threshold (config bits 20:11, unsigned). With bit 2 = 1, it matches when it is greater than or equal to the threshold. A result equal to the threshold therefore matches only with bit 2 = 1.
- R4: Each match increments the unit's counter. The flag sets on the edge that loads the match which brings the count to target+1 (target in config bits 10:7). Target 0 flags on the first match, and target 15 flags on the sixteenth.
- R5: A result examined under R1 that does not match sets the counter back to zero.
- R6: The counter returns to zero on the edge where the flag sets. A further flag therefore needs another target+1 matches.
- R7: Writing a unit's configuration with bit 0 = 0 returns its counter to zero.
- R8: Flags are sticky. Writing address 2 with bit i = 1 clears flag i. Bits written as 0 have no effect. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: `irq` is high while at least one unit has its flag set and its interrupt enable (config bit 1) set. Enabling the interrupt after the flag is already set raises `irq` at once.
- R10: The two units act independently on the same result stream. Both may examine the same load.
- R11: After reset, both flags and `irq` are 0 and both units are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_load | input | 1 | One-cycle strobe: a new conversion result is presented |
| res_chan | input | 4 | Channel number of the presented result (12 = band-gap) |
| res_data | input | 10 | Unsigned conversion result |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0/1 = unit configuration, 2 = status clear |
| reg_wdata | input | 21 | Write data |
| cmp_flag | output | 2 | Sticky compare flags, bit i for unit i |
| irq | output | 1 | Compare interrupt request (level) |

## Verification
The bench places results right at the threshold under both conditions. A design that used the wrong comparison operator would flag on an equal value when it should not, or miss one that should flag.

It breaks a run of matches with a non-matching result, and it disables and re-enables a unit part-way through a run. A counter that kept its count would flag one load too early.

It loads channel codes 13 and up while a unit selects them. It also collides a status clear with a flag set in the same cycle, expecting the flag to stay. It drives a target of 15, where an off-by-one design flags on the fifteenth or seventeenth match.

Two units watching one channel with opposite conditions expose any cross-talk between them.

// File: rtl/cmpmon_pkg.sv
package cmpmon_pkg;

    localparam int DATA_W  = 10;
    localparam int CHAN_W  = 4;
    localparam int CNT_W   = 4;
    localparam int MAX_SEL = 12;

    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_COND = 2;
    localparam int CHAN_LSB = 3;
    localparam int TGT_LSB  = CHAN_LSB + CHAN_W;
    localparam int THR_LSB  = TGT_LSB + CNT_W;
    localparam int REG_W    = THR_LSB + DATA_W;

    typedef struct packed {
        logic                en;
        logic                ie;
        logic                cond_ge;
        logic [CHAN_W-1:0]   chan;
        logic [CNT_W-1:0]    target;
        logic [DATA_W-1:0]   thresh;
    } unit_cfg_t;

    function automatic unit_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        unit_cfg_t c;
        c.en      = w[BIT_EN];
        c.ie      = w[BIT_IE];
        c.cond_ge = w[BIT_COND];
        c.chan    = w[CHAN_LSB +: CHAN_W];
        c.target  = w[TGT_LSB +: CNT_W];
        c.thresh  = w[THR_LSB +: DATA_W];
        return c;
    endfunction

endpackage

// File: rtl/cmpmon_regs.sv
module cmpmon_regs
    import cmpmon_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output unit_cfg_t            cfg      [NUM_UNITS],
    output logic [NUM_UNITS-1:0] cnt_rst,
    output logic [NUM_UNITS-1:0] flag_clr
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_UNITS);

    typedef struct packed {
        unit_cfg_t [NUM_UNITS-1:0] cfg;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic        stat_wr;
    logic        unused_stat_bits;

    assign stat_wr          = reg_we && (reg_addr == STAT_ADDR);
    assign unused_stat_bits = ^reg_wdata[REG_W-1:NUM_UNITS];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_UNITS; i++) begin
            cnt_rst[i]  = 1'b0;
            flag_clr[i] = stat_wr && reg_wdata[i];
            if (reg_we && (reg_addr == ADDR_W'(i))) begin
                st_d.cfg[i] = unpack_cfg(reg_wdata);
                cnt_rst[i]  = !reg_wdata[BIT_EN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_cfg_out
        assign cfg[g] = st_q.cfg[g];
    end

endmodule

// File: rtl/cmpmon_match.sv
module cmpmon_match
    import cmpmon_pkg::*;
#(
    parameter int D_W     = DATA_W,
    parameter int C_W     = CHAN_W,
    parameter int SEL_MAX = MAX_SEL
) (
    input  logic           res_load,
    input  logic [C_W-1:0] res_chan,
    input  logic [D_W-1:0] res_data,
    input  logic           en,
    input  logic           cond_ge,
    input  logic [C_W-1:0] sel,
    input  logic [D_W-1:0] thresh,
    output logic           hit,
    output logic           match
);

    logic sel_valid;
    logic ge;

    assign sel_valid = (sel <= C_W'(SEL_MAX));
    assign hit       = res_load && en && sel_valid && (res_chan == sel);
    assign ge        = (res_data >= thresh);
    assign match     = cond_ge ? ge : !ge;

endmodule

// File: rtl/cmpmon_counter.sv
module cmpmon_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          match,
    input  logic [CW-1:0] target,
    input  logic          cnt_rst,
    input  logic          flag_clr,
    output logic          flag
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       reach;

    assign reach = hit && match && (st_q.cnt == target);

    always_comb begin
        st_d = st_q;
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (reach) begin
            st_d.flag = 1'b1;
            st_d.cnt  = '0;
        end else if (cnt_rst) begin
            st_d.cnt = '0;
        end else if (hit && match) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (hit) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/result_cmp_monitor.sv
module result_cmp_monitor
    import cmpmon_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = $clog2(NUM_UNITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_load,
    input  logic [CHAN_W-1:0]    res_chan,
    input  logic [DATA_W-1:0]    res_data,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [NUM_UNITS-1:0] cmp_flag,
    output logic                 irq
);

    unit_cfg_t            cfg [NUM_UNITS];
    logic [NUM_UNITS-1:0] cnt_rst;
    logic [NUM_UNITS-1:0] flag_clr;
    logic [NUM_UNITS-1:0] irq_src;

    cmpmon_regs #(
        .NUM_UNITS (NUM_UNITS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cfg       (cfg),
        .cnt_rst   (cnt_rst),
        .flag_clr  (flag_clr)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        logic hit;
        logic match;

        cmpmon_match #(
            .D_W     (DATA_W),
            .C_W     (CHAN_W),
            .SEL_MAX (MAX_SEL)
        ) u_match (
            .res_load (res_load),
            .res_chan (res_chan),
            .res_data (res_data),
            .en       (cfg[g].en),
            .cond_ge  (cfg[g].cond_ge),
            .sel      (cfg[g].chan),
            .thresh   (cfg[g].thresh),
            .hit      (hit),
            .match    (match)
        );

        cmpmon_counter #(
            .CW (CNT_W)
        ) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit),
            .match    (match),
            .target   (cfg[g].target),
            .cnt_rst  (cnt_rst[g]),
            .flag_clr (flag_clr[g]),
            .flag     (cmp_flag[g])
        );

        assign irq_src[g] = cmp_flag[g] && cfg[g].ie;
    end

    assign irq = |irq_src;

endmodule

// File: rtl/cmpmon_checker.sv
module cmpmon_checker #(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 2,
    parameter int CHAN_W    = 4,
    parameter int MAX_SEL   = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 res_load,
    input logic [CHAN_W-1:0]    res_chan,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [NUM_UNITS-1:0] clr_bits,
    input logic [NUM_UNITS-1:0] cmp_flag,
    input logic                 irq
);

    logic stat_wr;
    assign stat_wr = reg_we && (reg_addr == ADDR_W'(NUM_UNITS));

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|cmp_flag)); // R9

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_chk
        AST_SET_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cmp_flag[g]) |-> $past(res_load)); // R1

        AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!res_load && !cmp_flag[g]) |=> !cmp_flag[g]); // R1

        AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cmp_flag[g]) |-> ($past(res_chan) <= CHAN_W'(MAX_SEL))); // R2

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_flag[g] && !(stat_wr && clr_bits[g])) |=> cmp_flag[g]); // R8

        AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cmp_flag[g]) |-> $past(stat_wr && clr_bits[g])); // R8
    end

endmodule

bind result_cmp_monitor cmpmon_checker #(
    .NUM_UNITS (NUM_UNITS),
    .ADDR_W    (ADDR_W),
    .CHAN_W    (cmpmon_pkg::CHAN_W),
    .MAX_SEL   (cmpmon_pkg::MAX_SEL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_load (res_load),
    .res_chan (res_chan),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .clr_bits (reg_wdata[NUM_UNITS-1:0]),
    .cmp_flag (cmp_flag),
    .irq      (irq)
);

// File: tb/tb_result_cmp_monitor.sv
`timescale 1ns/1ps
module tb_result_cmp_monitor;

    localparam int NV = 32;
    localparam logic [1:0] OP_LD = 2'd0, OP_CFG = 2'd1, OP_ST = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [20:0] wdata;
        logic [3:0]  chan;
        logic [9:0]  data;
        logic [1:0]  eflag;
        logic        eirq;
        logic [7:0]  req;
    } vec_t;

    // en bit0, ie bit1, cond bit2, chan 6:3, target 10:7, threshold 20:11
    function automatic logic [20:0] cfgw(input logic en, input logic ie, input logic ge,
                                         input logic [3:0] ch, input logic [3:0] tg,
                                         input logic [9:0] th);
        return {th, tg, ch, ge, ie, en};
    endfunction

    localparam vec_t VECS [NV] = '{
        '{OP_CFG, 2'd0, cfgw(1,0,0,3,1,100), 4'd0, 10'd0,   2'b00, 1'b0, 8'd4},  // R4 setup
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd50,  2'b00, 1'b0, 8'd4},               // R4 first of two
        '{OP_LD,  2'd0, 21'd0, 4'd4,  10'd10,  2'b00, 1'b0, 8'd1},               // R1 other channel
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd99,  2'b01, 1'b0, 8'd4},               // R4 second match
        '{OP_CFG, 2'd0, cfgw(1,1,0,3,1,100), 4'd0, 10'd0,   2'b01, 1'b1, 8'd9},  // R9 late enable
        '{OP_ST,  2'd0, 21'b10, 4'd0, 10'd0,   2'b01, 1'b1, 8'd8},               // R8 zero bit
        '{OP_ST,  2'd0, 21'b01, 4'd0, 10'd0,   2'b00, 1'b0, 8'd8},               // R8 clear
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd100, 2'b00, 1'b0, 8'd3},               // R3 equal, below-mode
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd5,   2'b00, 1'b0, 8'd3},               // R3
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd500, 2'b00, 1'b0, 8'd5},               // R5 breaks run
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd5,   2'b00, 1'b0, 8'd5},               // R5 restart
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd6,   2'b01, 1'b1, 8'd5},               // R5 flag after 2
        '{OP_ST,  2'd0, 21'b01, 4'd0, 10'd0,   2'b00, 1'b0, 8'd8},               // R8
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd5,   2'b00, 1'b0, 8'd6},               // R6 count from 0
        '{OP_CFG, 2'd0, cfgw(0,1,0,3,1,100), 4'd0, 10'd0,   2'b00, 1'b0, 8'd7},  // R7 disable
        '{OP_CFG, 2'd0, cfgw(1,1,0,3,1,100), 4'd0, 10'd0,   2'b00, 1'b0, 8'd7},  // R7 re-enable
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd5,   2'b00, 1'b0, 8'd7},               // R7 only one
        '{OP_CFG, 2'd0, cfgw(0,1,0,3,1,100), 4'd0, 10'd0,   2'b00, 1'b0, 8'd1},  // R1 disable
        '{OP_LD,  2'd0, 21'd0, 4'd3,  10'd5,   2'b00, 1'b0, 8'd1},               // R1 ignored
        '{OP_CFG, 2'd1, cfgw(1,1,1,12,0,1023), 4'd0, 10'd0, 2'b00, 1'b0, 8'd3},  // R3 setup
        '{OP_LD,  2'd0, 21'd0, 4'd12, 10'd1022, 2'b00, 1'b0, 8'd3},              // R3 below
        '{OP_LD,  2'd0, 21'd0, 4'd12, 10'd1023, 2'b10, 1'b1, 8'd3},              // R3 equal, R4 tgt 0
        '{OP_ST,  2'd0, 21'b10, 4'd0, 10'd0,   2'b00, 1'b0, 8'd8},               // R8
        '{OP_CFG, 2'd1, cfgw(1,0,1,13,0,0), 4'd0, 10'd0,    2'b00, 1'b0, 8'd2},  // R2 code 13
        '{OP_LD,  2'd0, 21'd0, 4'd13, 10'd500, 2'b00, 1'b0, 8'd2},               // R2 no match
        '{OP_CFG, 2'd1, cfgw(1,0,1,0,0,0), 4'd0, 10'd0,     2'b00, 1'b0, 8'd2},  // R2 code 0
        '{OP_LD,  2'd0, 21'd0, 4'd0,  10'd0,   2'b10, 1'b0, 8'd2},               // R2, R9 no irq
        '{OP_ST,  2'd0, 21'b10, 4'd0, 10'd0,   2'b00, 1'b0, 8'd8},               // R8
        '{OP_CFG, 2'd0, cfgw(1,0,1,5,0,0), 4'd0, 10'd0,     2'b00, 1'b0, 8'd10}, // R10
        '{OP_CFG, 2'd1, cfgw(1,1,0,5,0,0), 4'd0, 10'd0,     2'b00, 1'b0, 8'd10}, // R10
        '{OP_LD,  2'd0, 21'd0, 4'd5,  10'd7,   2'b01, 1'b0, 8'd10},              // R10 only u0
        '{OP_ST,  2'd0, 21'b11, 4'd0, 10'd0,   2'b00, 1'b0, 8'd10}               // R10 clear both
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_load = 1'b0;
    logic [3:0]  res_chan = '0;
    logic [9:0]  res_data = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [20:0] reg_wdata = '0;
    logic [1:0]  cmp_flag;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    result_cmp_monitor dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_load  (res_load),
        .res_chan  (res_chan),
        .res_data  (res_data),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmp_flag  (cmp_flag),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [1:0] ef, input logic ei);
        checks++;
        if (cmp_flag !== ef || irq !== ei) begin
            fails++;
            $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b", tag, cmp_flag, irq, ef, ei);
        end
    endtask

    // drive at a falling edge, one rising edge, back at the falling edge
    task automatic step(input logic ld, input logic [3:0] ch, input logic [9:0] d,
                        input logic we, input logic [1:0] a, input logic [20:0] w);
        res_load = ld; res_chan = ch; res_data = d;
        reg_we = we; reg_addr = a; reg_wdata = w;
        @(negedge clk);
        res_load = 1'b0; reg_we = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 in reset", 2'b00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", 2'b00, 1'b0);

        for (int k = 0; k < NV; k++) begin
            vec_t v = VECS[k];
            step(v.op == OP_LD, v.chan, v.data, v.op != OP_LD,
                 (v.op == OP_ST) ? 2'd2 : v.addr, v.wdata);
            chk($sformatf("R%0d vector %0d", v.req, k), v.eflag, v.eirq);
        end

        // R4: target 15 needs sixteen matches
        step(0, 0, 0, 1, 2'd0, cfgw(1, 0, 1, 11, 15, 0));
        for (int n = 0; n < 15; n++) step(1, 4'd11, 10'd3, 0, 0, 0);
        chk("R4 fifteen matches", 2'b00, 1'b0);
        step(1, 4'd11, 10'd3, 0, 0, 0);
        chk("R4 sixteenth match", 2'b01, 1'b0);

        // R8: set and clear in the same cycle, set wins
        step(0, 0, 0, 1, 2'd0, cfgw(1, 1, 1, 11, 0, 0));
        step(1, 4'd11, 10'd1, 1, 2'd2, 21'b01);
        chk("R8 set beats clear", 2'b01, 1'b1);

        // R11: reset in the middle clears flags
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mid-run reset", 2'b00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        step(1, 4'd11, 10'd1, 0, 0, 0);
        chk("R11 units disabled", 2'b00, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule